// File: doc/BRIEF.md
# USB Frame Timer with Pseudo Start-of-Frame

This block keeps the local view of the USB frame sequence. Each start-of-frame token that arrives with a good token check hands it an 11-bit frame number. The block latches that number and raises a one-cycle frame strobe. It also counts full-speed bit times, at 12 per microsecond, from the start of the current frame.

If no good token arrives by the nominal frame length plus a guard margin, the block does the work itself. It raises a one-cycle pseudo-frame strobe at that moment, steps the stored frame number by one and starts timing the next frame. The stored frame number therefore advances once per frame even when tokens are lost. Software or other logic can read it as a time stamp.

A small read channel returns either the frame number or the bit-time phase within the current frame. Requests and responses each use a valid/ready handshake. A request is accepted only while no response is waiting, or while the waiting response is being taken in the same cycle. A response that is waiting holds its data stable until it is taken.

Top module: `usb_frame_tracker`

## Requirements
- R1: After reset the frame number reads 0, both strobes are low, no response is pending and `rd_req_ready` is high.
- R2: A start-of-frame strobe with the token-valid flag high loads the frame number from `sof_frame_num`. On the next clock the number appears on `frame_num_o` and `sof_pulse_o` is high for exactly one cycle.
- R3: A start-of-frame strobe with the token-valid flag low is ignored. The frame number is unchanged, no frame strobe is raised, and the missing-frame timing is not restarted.
- R4: Once synchronised, if FRAME_TICKS+GUARD_TICKS bit ticks pass after the last valid token with no new valid token, `psof_pulse_o` is high for one cycle. It is raised in the cycle after that tick, and the frame number steps by one in the same cycle.
- R5: After a pseudo strobe, further pseudo strobes follow every FRAME_TICKS bit ticks for as long as no valid token arrives. The phase restarts at GUARD_TICKS.
- R6: The frame number wraps from 2047 to 0.
- R7: A valid token restarts the phase at 0 and overwrites any locally stepped frame number. If it coincides with the tick that would raise a pseudo strobe, the token wins and no pseudo strobe occurs.
- R8: No pseudo strobe occurs before the first valid token after reset, however many ticks pass.
- R9: Read address 0 (`rd_req_addr`=0) returns the frame number zero-extended to 16 bits. Address 1 returns the bit-tick phase, which is the number of ticks since the start of the current nominal frame. The response is valid in the cycle after the request is accepted and carries the value held at acceptance.
- R10: While a response is valid and `rd_rsp_ready` is low, `rd_req_ready` is low and `rd_rsp_data` stays unchanged.
- R11: Cycles with `bit_tick` low do not advance the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle enable per full-speed bit time |
| sof_rx | input | 1 | Start-of-frame token received strobe |
| sof_frame_num | input | 11 | Frame number carried by the token |
| sof_tok_ok | input | 1 | Token passed its checks |
| frame_num_o | output | 11 | Current frame number |
| sof_pulse_o | output | 1 | One-cycle strobe on a valid token |
| psof_pulse_o | output | 1 | One-cycle strobe for a filled-in frame |
| rd_req_valid | input | 1 | Read request valid |
| rd_req_ready | output | 1 | Read request accepted |
| rd_req_addr | input | 1 | 0: frame number, 1: tick phase |
| rd_rsp_valid | output | 1 | Read response valid |
| rd_rsp_ready | input | 1 | Read response taken |
| rd_rsp_data | output | 16 | Read response data |

## Verification
Every result is due one clock after the edge that registers its cause:
- The frame number and frame strobe follow the clock edge that sees the token.
- The pseudo strobe and the stepped number follow the edge of the last tick that completes the window.
- A read response follows the edge that accepts the request.

The bench changes inputs on falling edges and samples on the next falling edge, half a cycle after the result is due. This catches one-cycle strobes exactly. For multi-tick runs it checks the flag on the cycle after the final tick, and on the tick just before it to confirm no early pseudo strobe.

// File: rtl/ft_pkg.sv
package ft_pkg;
  localparam int FN_W = 11;
  localparam int RD_W = 16;
  typedef enum logic { REG_FRAME = 1'b0, REG_PHASE = 1'b1 } ft_reg_e;
endpackage

// File: rtl/ft_tick_timer.sv
module ft_tick_timer #(
  parameter int FRAME_TICKS = 12000,
  parameter int GUARD_TICKS = 16,
  parameter int CNT_W       = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             sof_ok,
  output logic             psof_fire,
  output logic [CNT_W-1:0] phase
);
  localparam int LIMIT = FRAME_TICKS + GUARD_TICKS;

  logic synced;

  // The window closes on the tick that would make the phase reach LIMIT.
  assign psof_fire = synced && bit_tick && !sof_ok && (phase == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced <= 1'b0;
      phase  <= '0;
    end else if (sof_ok) begin
      synced <= 1'b1;
      phase  <= '0;
    end else if (psof_fire) begin
      phase  <= CNT_W'(GUARD_TICKS);
    end else if (bit_tick && synced) begin
      phase  <= phase + 1'b1;
    end
  end

  // R5: the phase never passes the end of the window
  a_r5_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    phase < CNT_W'(LIMIT));
  // R8: before the first good token, the phase stays at zero
  a_r8_idle_until_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> phase == '0);
  // R11: without a tick or a token, the phase holds
  a_r11_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !sof_ok) |=> $stable(phase));
endmodule

// File: rtl/ft_frame_reg.sv
module ft_frame_reg
  import ft_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sof_ok,
  input  logic [FN_W-1:0] sof_num,
  input  logic            psof_fire,
  output logic [FN_W-1:0] frame_num,
  output logic            sof_pulse,
  output logic            psof_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_num  <= '0;
      sof_pulse  <= 1'b0;
      psof_pulse <= 1'b0;
    end else begin
      sof_pulse  <= sof_ok;
      psof_pulse <= psof_fire;
      if (sof_ok)         frame_num <= sof_num;
      else if (psof_fire) frame_num <= frame_num + 1'b1;
    end
  end

  // R4, R6: a pseudo strobe comes with a modulo-2048 step of the number
  a_r4_psof_steps: assert property (@(posedge clk) disable iff (!rst_n)
    psof_pulse |-> frame_num == FN_W'($past(frame_num) + 1'b1));
  // R7: the two strobes never coincide
  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sof_pulse, psof_pulse}));
endmodule

// File: rtl/ft_read_port.sv
module ft_read_port
  import ft_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FN_W-1:0]  frame_num,
  input  logic [CNT_W-1:0] phase,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_addr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [RD_W-1:0]  rsp_data
);
  logic    req_fire;
  ft_reg_e sel;

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;
  assign sel       = ft_reg_e'(req_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (req_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= (sel == REG_PHASE) ? RD_W'(phase) : RD_W'(frame_num);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10: a stalled response holds its data and stays valid
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data));
  // R10: no request is accepted while a stalled response is pending
  a_r10_no_accept_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

// File: rtl/usb_frame_tracker.sv
module usb_frame_tracker
  import ft_pkg::*;
#(
  parameter int FRAME_TICKS = 12000,
  parameter int GUARD_TICKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              sof_rx,
  input  logic [10:0]       sof_frame_num,
  input  logic              sof_tok_ok,
  output logic [10:0]       frame_num_o,
  output logic              sof_pulse_o,
  output logic              psof_pulse_o,
  input  logic              rd_req_valid,
  output logic              rd_req_ready,
  input  logic              rd_req_addr,
  output logic              rd_rsp_valid,
  input  logic              rd_rsp_ready,
  output logic [15:0]       rd_rsp_data
);
  localparam int CNT_W = $clog2(FRAME_TICKS + GUARD_TICKS + 1);

  logic             sof_ok;
  logic             psof_fire;
  logic [CNT_W-1:0] phase;

  assign sof_ok = sof_rx && sof_tok_ok;

  ft_tick_timer #(
    .FRAME_TICKS(FRAME_TICKS),
    .GUARD_TICKS(GUARD_TICKS),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .sof_ok   (sof_ok),
    .psof_fire(psof_fire),
    .phase    (phase)
  );

  ft_frame_reg u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sof_ok    (sof_ok),
    .sof_num   (sof_frame_num),
    .psof_fire (psof_fire),
    .frame_num (frame_num_o),
    .sof_pulse (sof_pulse_o),
    .psof_pulse(psof_pulse_o)
  );

  ft_read_port #(.CNT_W(CNT_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_num(frame_num_o),
    .phase    (phase),
    .req_valid(rd_req_valid),
    .req_ready(rd_req_ready),
    .req_addr (rd_req_addr),
    .rsp_valid(rd_rsp_valid),
    .rsp_ready(rd_rsp_ready),
    .rsp_data (rd_rsp_data)
  );

  // R2: a good token loads its number and raises the frame strobe
  a_r2_sof_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_rx && sof_tok_ok) |=> sof_pulse_o && frame_num_o == $past(sof_frame_num));
  // R3: a bad token alone neither strobes nor changes the number
  a_r3_bad_token_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_rx && !sof_tok_ok && !psof_fire) |=> !sof_pulse_o && $stable(frame_num_o));
endmodule

// File: tb/usb_frame_tracker_tb.sv
module usb_frame_tracker_tb;
  localparam int FT = 40;
  localparam int GT = 4;
  localparam int NV = 16;
  // entry: {op[1:0], arg[10:0], exp_fn[10:0], exp_sof, exp_psof}
  // op 0: arg bit ticks, 1: good token with number arg, 2: bad token with number arg
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 11'd50,   11'd0,    1'b0, 1'b0},  // R8
    {2'd1, 11'd100,  11'd100,  1'b1, 1'b0},  // R2
    {2'd0, 11'd43,   11'd100,  1'b0, 1'b0},  // R4 not yet
    {2'd0, 11'd1,    11'd101,  1'b0, 1'b1},  // R4
    {2'd0, 11'd39,   11'd101,  1'b0, 1'b0},  // R5 not yet
    {2'd0, 11'd1,    11'd102,  1'b0, 1'b1},  // R5
    {2'd2, 11'd7,    11'd102,  1'b0, 1'b0},  // R3
    {2'd0, 11'd39,   11'd102,  1'b0, 1'b0},  // R3 no restart
    {2'd0, 11'd1,    11'd103,  1'b0, 1'b1},  // R5
    {2'd1, 11'd2046, 11'd2046, 1'b1, 1'b0},  // R2
    {2'd0, 11'd44,   11'd2047, 1'b0, 1'b1},  // R4
    {2'd0, 11'd40,   11'd0,    1'b0, 1'b1},  // R6 wrap
    {2'd1, 11'd500,  11'd500,  1'b1, 1'b0},  // R7 overwrite
    {2'd0, 11'd43,   11'd500,  1'b0, 1'b0},  // R7 restart
    {2'd1, 11'd501,  11'd501,  1'b1, 1'b0},  // R7 mid-frame
    {2'd0, 11'd44,   11'd502,  1'b0, 1'b1}   // R7 window from new token
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_tick = 1'b0, sof_rx = 1'b0, sof_tok_ok = 1'b0;
  logic [10:0] sof_frame_num = '0;
  logic [10:0] frame_num_o;
  logic sof_pulse_o, psof_pulse_o;
  logic rd_req_valid = 1'b0, rd_req_addr = 1'b0, rd_rsp_ready = 1'b1;
  logic rd_req_ready, rd_rsp_valid;
  logic [15:0] rd_rsp_data;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_frame_tracker #(.FRAME_TICKS(FT), .GUARD_TICKS(GT)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sof_rx(sof_rx),
    .sof_frame_num(sof_frame_num), .sof_tok_ok(sof_tok_ok),
    .frame_num_o(frame_num_o), .sof_pulse_o(sof_pulse_o), .psof_pulse_o(psof_pulse_o),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1;
      @(negedge clk);
    end
    bit_tick = 1'b0;
  endtask

  task automatic token(input logic ok, input logic [10:0] num);
    sof_rx = 1'b1; sof_tok_ok = ok; sof_frame_num = num;
    @(negedge clk);
    sof_rx = 1'b0; sof_tok_ok = 1'b0;
  endtask

  task automatic rd(input logic addr, output int data);
    rd_req_valid = 1'b1; rd_req_addr = addr;
    @(negedge clk);
    rd_req_valid = 1'b0;
    data = int'(rd_rsp_data);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 frame", int'(frame_num_o), 0);
    check("R1 sof", int'(sof_pulse_o), 0);
    check("R1 psof", int'(psof_pulse_o), 0);
    check("R1 rsp_valid", int'(rd_rsp_valid), 0);
    check("R1 req_ready", int'(rd_req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      case (VEC[v][25:24])
        2'd0: ticks(int'(VEC[v][23:13]));
        2'd1: token(1'b1, VEC[v][23:13]);
        default: token(1'b0, VEC[v][23:13]);
      endcase
      check($sformatf("vec%0d R2/R3/R4/R5/R6/R7/R8 frame", v), int'(frame_num_o), int'(VEC[v][12:2]));
      check($sformatf("vec%0d R2 sof", v), int'(sof_pulse_o), int'(VEC[v][1]));
      check($sformatf("vec%0d R4 psof", v), int'(psof_pulse_o), int'(VEC[v][0]));
    end

    // R11 and R9: phase frozen without ticks, read back both registers
    token(1'b1, 11'd10);
    repeat (30) @(negedge clk);
    rd(1'b1, d); check("R11 phase frozen", d, 0);
    check("R9 rsp_valid", int'(rd_rsp_valid), 1);
    ticks(5);
    rd(1'b1, d); check("R9 phase read", d, 5);
    rd(1'b0, d); check("R9 frame read", d, 10);

    // R10 back-pressure
    rd_rsp_ready = 1'b0;
    rd(1'b0, d); check("R10 first data", d, 10);
    token(1'b1, 11'd33);
    rd_req_valid = 1'b1; rd_req_addr = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R10 req_ready low", int'(rd_req_ready), 0);
      check("R10 data held", int'(rd_rsp_data), 10);
    end
    rd_req_valid = 1'b0;
    rd_rsp_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10 released", int'(rd_rsp_valid), 0);

    // R7 token coinciding with the closing tick
    token(1'b1, 11'd700);
    ticks(GT + FT - 1);
    sof_rx = 1'b1; sof_tok_ok = 1'b1; sof_frame_num = 11'd900; bit_tick = 1'b1;
    @(negedge clk);
    sof_rx = 1'b0; sof_tok_ok = 1'b0; bit_tick = 1'b0;
    check("R7 token wins frame", int'(frame_num_o), 900);
    check("R7 token wins psof", int'(psof_pulse_o), 0);
    check("R7 token wins sof", int'(sof_pulse_o), 1);

    // R8 after a new reset, no pseudo strobe
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    ticks(GT + FT + 5);
    check("R8 no psof after reset", int'(psof_pulse_o), 0);
    check("R8 frame after reset", int'(frame_num_o), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule